// File: doc/BRIEF.md
# Pause-Width Scrambled Frame Transmitter

This block sends a reader command frame of 1 to 32 bits over a single carrier-gating output. A start request captures the frame word, its length and a reference timestamp, which is the end of the previous frame on air. The block then waits a fixed gap after that timestamp. It sends each bit as a short carrier-off pause followed by carrier-on time. The total length of the bit, not the pause, carries its value. A final pause closes the frame.

Every bit on air is the frame bit XOR a keystream bit from an external pseudorandom generator. After each bit the block pulses an advance request to that generator. All edges follow from a shared tick counter supplied at the `now` input, running at 1.5 ticks per microsecond. Each edge is placed by adding a fixed step to the previous scheduled deadline, so the timing does not drift. The block reports the scheduled start and end of the frame in ticks, so the next frame can be placed from `t_end`.

Top module: `pause_frame_tx`

## Requirements
- R1: Every edge is scheduled by adding to the previous deadline. `t_end - t_start` equals the sum of the bit durations plus one closing pause.
- R2: The first pause begins at tick `last_end + 330`, and `t_start` reports that tick.
- R3: Every pause, including the closing one, holds `pause_out` high for exactly 30 ticks.
- R4: A bit whose on-air value is 1 lasts 150 ticks from one pause start to the next. An on-air 0 lasts 90 ticks.
- R5: Bits go out from `frame[0]` upward. Only `len` bits are sent, and frame bits at or above `len` have no effect.
- R6: The on-air bit is `frame[i] ^ ks_bit`, with `ks_bit` sampled during that bit's pause. `ks_advance` pulses for one cycle per bit, at the start of the following pause.
- R7: After the last bit, one closing 30-tick pause is sent and `pause_out` returns low. `t_end` reports the tick of that return.
- R8: `done` is a single-cycle pulse in the cycle the carrier returns on, and `busy` is low from then on.
- R9: After reset, and whenever idle, `pause_out`, `busy`, `done` and `ks_advance` are low.
- R10: A start request while busy is ignored. The current frame is unchanged and no second frame follows.
- R11: Deadline comparison is modulo 2^32, so frames that cross the tick counter wrap keep correct timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send a frame (accepted when idle) |
| frame | input | 32 | Frame word, bit 0 sent first |
| len | input | 6 | Number of bits to send, 1 to 32 |
| last_end | input | 32 | Tick timestamp of the previous frame end |
| now | input | 32 | Shared free-running tick counter |
| ks_bit | input | 1 | Current keystream bit |
| pause_out | output | 1 | High while the carrier is paused |
| ks_advance | output | 1 | One-cycle request to step the keystream |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| t_start | output | 32 | Scheduled tick of the first pause |
| t_end | output | 32 | Scheduled tick of the final carrier return |

## Verification
The hardest case to reach is a frame whose deadlines cross the tick counter wrap. The bench starts its tick counter a few hundred ticks below 2^32, so the first table vector's gap and bits straddle the wrap. A second hard case is a start request in the middle of a long frame. The bench injects one partway through the 32-bit vector and then watches the line stay quiet afterwards. Bit values are recovered only from the spacing of pause rising edges and unscrambled with a keystream model kept in the bench.

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int TS_W    = 32,
  parameter int FRAME_W = 32,
  parameter int LEN_W   = $clog2(FRAME_W + 1),
  parameter int GAP     = 330,
  parameter int PAUSE   = 30,
  parameter int LONG    = 150,
  parameter int SHORT   = 90
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  input  logic [TS_W-1:0]    last_end,
  input  logic [TS_W-1:0]    now,
  input  logic               ks_bit,
  output logic               pause_out,
  output logic               ks_advance,
  output logic               busy,
  output logic               done,
  output logic [TS_W-1:0]    t_start,
  output logic [TS_W-1:0]    t_end
);
  localparam logic [TS_W-1:0] GAP_T   = TS_W'(GAP);
  localparam logic [TS_W-1:0] PAUSE_T = TS_W'(PAUSE);
  localparam logic [TS_W-1:0] MARK1_T = TS_W'(LONG - PAUSE);
  localparam logic [TS_W-1:0] MARK0_T = TS_W'(SHORT - PAUSE);

  typedef enum logic [2:0] {IDLE, GAPW, PAUSEW, MARKW, TAILW} st_t;
  st_t st;

  logic [TS_W-1:0]    deadline;
  logic [FRAME_W-1:0] word;
  logic [LEN_W-1:0]   nbits, idx;
  logic [TS_W-1:0]    slack;
  logic               due, air_bit;

  assign slack   = now - deadline;
  assign due     = ~slack[TS_W-1];
  assign air_bit = word[0] ^ ks_bit;
  assign busy    = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= IDLE;
      deadline   <= '0;
      word       <= '0;
      nbits      <= '0;
      idx        <= '0;
      pause_out  <= 1'b0;
      ks_advance <= 1'b0;
      done       <= 1'b0;
      t_start    <= '0;
      t_end      <= '0;
    end else begin
      ks_advance <= 1'b0;
      done       <= 1'b0;
      unique case (st)
        IDLE: if (start) begin
          deadline <= last_end + GAP_T;
          word     <= frame;
          nbits    <= len;
          idx      <= '0;
          st       <= GAPW;
        end
        GAPW: if (due) begin
          t_start   <= deadline;
          pause_out <= 1'b1;
          deadline  <= deadline + PAUSE_T;
          st        <= PAUSEW;
        end
        PAUSEW: if (due) begin
          pause_out <= 1'b0;
          deadline  <= deadline + (air_bit ? MARK1_T : MARK0_T);
          st        <= MARKW;
        end
        MARKW: if (due) begin
          ks_advance <= 1'b1;
          pause_out  <= 1'b1;
          deadline   <= deadline + PAUSE_T;
          word       <= word >> 1;
          idx        <= idx + 1'b1;
          st         <= (idx == nbits - 1'b1) ? TAILW : PAUSEW;
        end
        TAILW: if (due) begin
          pause_out <= 1'b0;
          t_end     <= deadline;
          done      <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pause_frame_tx_chk.sv
module pause_frame_tx_chk #(
  parameter int TS_W  = 32,
  parameter int PAUSE = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pause_out,
  input logic            ks_advance,
  input logic            busy,
  input logic            done,
  input logic [TS_W-1:0] t_start
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          hi_cnt <= '0;
    else if (!pause_out) hi_cnt <= '0;
    else                 hi_cnt <= hi_cnt + 1'b1;

  p_pause_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_out) |-> hi_cnt == 16'(PAUSE));
  p_adv_at_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_advance |-> (pause_out && busy));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pause_out && !ks_advance));
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pause_out && !ks_advance));
  p_tstart_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pause_out && $past(pause_out)) |-> $stable(t_start));
endmodule

bind pause_frame_tx pause_frame_tx_chk #(.TS_W(TS_W), .PAUSE(PAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause_out(pause_out), .ks_advance(ks_advance),
  .busy(busy), .done(done), .t_start(t_start));

// File: tb/tb_pause_frame_tx.sv
module tb_pause_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] frame = '0;
  logic [5:0]  len = 6'd1;
  logic [31:0] last_end = '0;
  logic [31:0] now = 32'hFFFF_FE80;
  logic        ks_load = 1'b0;
  logic [7:0]  ks_seed = '0;
  logic [7:0]  lfsr = '0;
  logic        pause_out, ks_advance, busy, done;
  logic [31:0] t_start, t_end;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) now <= now + 1;

  function automatic logic [7:0] nxt(input logic [7:0] l);
    return {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
  endfunction

  always @(posedge clk)
    if (ks_load) lfsr <= ks_seed;
    else if (ks_advance) lfsr <= nxt(lfsr);

  pause_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame), .len(len),
    .last_end(last_end), .now(now), .ks_bit(lfsr[0]),
    .pause_out(pause_out), .ks_advance(ks_advance), .busy(busy), .done(done),
    .t_start(t_start), .t_end(t_end));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [45:0] VEC [NV] = '{
    {32'h0000_0001, 6'd7,  8'h00},
    {32'h0000_0019, 6'd6,  8'hA5},
    {32'hDEAD_BEEF, 6'd32, 8'h3C},
    {32'h0000_0000, 6'd1,  8'h01},
    {32'h0000_0001, 6'd1,  8'h00},
    {32'hFFF1_2345, 6'd13, 8'hFF}
  };

  task automatic run_frame(input logic [31:0] f, input logic [5:0] n, input logic [7:0] seed,
                           input bit inject, input bit expect_wrap);
    logic [31:0] rise [0:33];
    logic [31:0] kb, lastfall, base, total;
    logic [7:0]  l;
    int rises, advs, cyc;
    bit prevp, width_ok, dur_ok, data_ok;
    l = seed;
    for (int i = 0; i < 32; i++) begin kb[i] = l[0]; l = nxt(l); end
    @(negedge clk); ks_seed = seed; ks_load = 1'b1;
    @(negedge clk); ks_load = 1'b0;
    base = now; last_end = base; frame = f; len = n; start = 1'b1;
    @(negedge clk); start = 1'b0; frame = ~f;
    rises = 0; advs = 0; cyc = 0; prevp = 1'b0; width_ok = 1'b1; lastfall = '0;
    while (!done && cyc < 6000) begin
      @(negedge clk); cyc++;
      if (inject && cyc == 800) begin start = 1'b1; frame = 32'h0; len = 6'd1; last_end = now; end
      if (inject && cyc == 801) start = 1'b0;
      if (pause_out && !prevp && rises < 34) begin rise[rises] = now; rises++; end
      if (!pause_out && prevp) begin
        lastfall = now;
        if (now - rise[rises-1] != 32'd30) width_ok = 1'b0;
      end
      if (ks_advance) advs++;
      prevp = pause_out;
    end
    chk(done, "R8 done seen", {31'd0, done}, 32'd1);
    chk(rises > 0 && rise[0] - 32'd1 == base + 32'd330, "R2 first pause tick", rise[0] - 32'd1, base + 32'd330);
    chk(t_start == base + 32'd330, "R2 t_start", t_start, base + 32'd330);
    chk(width_ok, "R3 pause width", {31'd0, width_ok}, 32'd1);
    chk(rises == int'(n) + 1, "R7 pause count incl closing", rises, n + 1);
    chk(advs == int'(n), "R6 advance count", advs, n);
    dur_ok = 1'b1; data_ok = 1'b1; total = 32'd30;
    for (int i = 0; i < int'(n) && i + 1 < rises; i++) begin
      logic [31:0] d;
      d = rise[i+1] - rise[i];
      if (d != 32'd150 && d != 32'd90) dur_ok = 1'b0;
      if (((d == 32'd150) ^ kb[i]) != f[i]) data_ok = 1'b0;
      total += ((f[i] ^ kb[i]) ? 32'd150 : 32'd90);
    end
    chk(dur_ok, "R4 bit durations", {31'd0, dur_ok}, 32'd1);
    chk(data_ok, "R5 R6 descrambled bits", {31'd0, data_ok}, 32'd1);
    chk(t_end == lastfall - 32'd1, "R7 t_end", t_end, lastfall - 32'd1);
    chk(t_end - t_start == total, "R1 frame span", t_end - t_start, total);
    if (expect_wrap) chk(t_end < t_start, "R11 wrap crossed", t_end, t_start);
    @(negedge clk);
    chk(!busy && !pause_out && !done, "R8 idle after done", {29'd0, busy, pause_out, done}, 32'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pause_out && !busy && !done && !ks_advance, "R9 reset state",
        {28'd0, pause_out, busy, done, ks_advance}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pause_out && !busy, "R9 idle after reset", {30'd0, pause_out, busy}, 32'd0);
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][45:14], VEC[v][13:8], VEC[v][7:0], 1'b0, v == 0);
    run_frame(32'hA5A5_C3C3, 6'd32, 8'h5E, 1'b1, 1'b0);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        if (busy || pause_out) quiet = 1'b0;
      end
      chk(quiet, "R10 no frame from ignored start", {31'd0, quiet}, 32'd1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule